// File: doc/BRIEF.md
# Ethernet Sleep-Mode Controller

This block keeps the power-management state of an Ethernet MAC. Software can put the MAC to sleep in two ways: by writing a sleep command on a 4-bit command port, or by setting one of two wake-source enable bits. The first source is a Magic Packet detector and the second is a pattern-filter wake-frame detector. The block records which of the two routes was taken, and that route decides which events may end the sleep.

While the block sleeps, it qualifies the detection pulses from the two frame detectors. Each accepted detection sets a sticky event flag. If the power-mode interrupt enable is set, it also sets a sticky interrupt flag, and the interrupt request output is that flag gated by a global interrupt enable. A wake-up does not restore normal operation straight away. The controller stays in a woken but not normal state until software has cleared every enable bit and every flag. If the sleep was entered by command, software must also have issued the leave-sleep command.

Command codes: 4'b1100 means enter sleep and 4'b1101 means leave sleep. Every other code is ignored.

Top module: `eth_sleep_ctrl`

## Requirements
- R1: In normal operation, a valid command 4'b1100 makes `asleep` 1 and `entry_by_cmd` 1 on the next cycle.
- R2: In normal operation with no sleep command, either wake enable bit being 1 makes `asleep` 1 and `entry_by_cmd` 0 on the next cycle.
- R3: After a command entry, sleep ends on the next cycle after a leave command 4'b1101 or after a detection pulse from either source, whatever its enable bit holds.
- R4: After an enable-bit entry, the leave command has no effect. Sleep ends only on a detection from a source whose enable bit is 1.
- R5: An accepted Magic Packet detection sets `evt_flags[5]` and an accepted pattern-frame detection sets `evt_flags[6]`, both on the next cycle. All other bits of `evt_flags` are always 0.
- R6: An accepted detection sets `pm_flag` only when `pm_int_en` is 1. `irq` equals `pm_flag` AND `glb_int_en`.
- R7: Each flag stays set until its clear strobe, and the strobe clears it on the next cycle.
- R8: `normal_op` returns only after a cycle in which both enables, both event flags and `pm_flag` are all 0, and, after a command entry, the leave command has been seen. `entry_by_cmd` is 0 once normal operation is back.
- R9: Command codes other than 4'b1100 and 4'b1101 have no effect. A sleep command while asleep or woken has no effect.
- R10: Detection pulses that arrive while `asleep` is 0 set no flag.
- R11: After reset, `normal_op` is 1 and `asleep`, `entry_by_cmd`, `evt_flags`, `pm_flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code |
| mp_wake_en | input | 1 | Magic Packet wake enable |
| wf_wake_en | input | 1 | Pattern-frame wake enable |
| pm_int_en | input | 1 | Power-mode interrupt enable |
| glb_int_en | input | 1 | Global interrupt enable |
| mp_detect | input | 1 | Magic Packet detection pulse |
| wf_detect | input | 1 | Pattern-frame detection pulse |
| clr_mp_evt | input | 1 | Clear strobe for event bit 5 |
| clr_wf_evt | input | 1 | Clear strobe for event bit 6 |
| clr_pm_flag | input | 1 | Clear strobe for the interrupt flag |
| asleep | output | 1 | Sleep state |
| normal_op | output | 1 | Full normal operation |
| entry_by_cmd | output | 1 | Sleep was entered by command |
| evt_flags | output | 8 | Sticky wake event flags |
| pm_flag | output | 1 | Sticky power-mode interrupt flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the woken-but-not-normal state. Reaching it takes a command entry, then a frame wake, then every flag cleared, and still the leave command is missing. A random stream also rarely keeps a command-entered sleep alive long enough to try a detection from a disabled source. Directed sequences therefore walk both entry routes through wake, clear and resume in order. A random phase follows in which enable bits change rarely and commands and detections are weighted toward the codes and pulses that matter. In that phase every output is compared against a bench model on every cycle.

// File: rtl/eth_sleep_pkg.sv
package eth_sleep_pkg;

    localparam int NSRC = 2;   // source 0: Magic Packet, source 1: pattern frame

    typedef enum logic [1:0] {
        PM_NORMAL = 2'd0,
        PM_SLEEP  = 2'd1,
        PM_WOKEN  = 2'd2
    } pm_state_e;

    typedef struct packed {
        pm_state_e state;
        logic      by_cmd;
        logic      exit_seen;
    } ctrl_s;

    typedef struct packed {
        logic [NSRC-1:0] src;
        logic            pm;
    } flags_s;

endpackage

// File: rtl/esc_cmd_decode.sv
module esc_cmd_decode #(
    parameter int               CMD_W      = 4,
    parameter logic [CMD_W-1:0] SLEEP_CODE = 4'b1100,
    parameter logic [CMD_W-1:0] LEAVE_CODE = 4'b1101
) (
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    output logic             go_sleep,
    output logic             go_leave
);
    always_comb begin
        go_sleep = cmd_valid && (cmd_code == SLEEP_CODE);
        go_leave = cmd_valid && (cmd_code == LEAVE_CODE);
    end
endmodule

// File: rtl/esc_wake_qual.sv
module esc_wake_qual
    import eth_sleep_pkg::*;
(
    input  logic            asleep,
    input  logic            by_cmd,
    input  logic [NSRC-1:0] detect,
    input  logic [NSRC-1:0] enable,
    output logic [NSRC-1:0] accepted,
    output logic            any_wake
);
    // In command mode any source may wake; otherwise only enabled ones.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign accepted[g] = asleep && detect[g] && (by_cmd || enable[g]);
    end

    assign any_wake = |accepted;
endmodule

// File: rtl/esc_event_flags.sv
module esc_event_flags
    import eth_sleep_pkg::*;
#(
    parameter int EVT_W  = 8,
    parameter int MP_BIT = 5,
    parameter int WF_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  accepted,
    input  logic             any_wake,
    input  logic [NSRC-1:0]  clr_src,
    input  logic             clr_pm,
    input  logic             pm_int_en,
    input  logic             glb_int_en,
    output logic [NSRC-1:0]  src_flags,
    output logic [EVT_W-1:0] evt_flags,
    output logic             pm_flag,
    output logic             irq
);
    flags_s f_d, f_q;

    always_comb begin
        f_d = f_q;
        for (int i = 0; i < NSRC; i++) begin
            if (accepted[i])     f_d.src[i] = 1'b1;
            else if (clr_src[i]) f_d.src[i] = 1'b0;
        end
        if (any_wake && pm_int_en) f_d.pm = 1'b1;
        else if (clr_pm)           f_d.pm = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    always_comb begin
        evt_flags         = '0;
        evt_flags[MP_BIT] = f_q.src[0];
        evt_flags[WF_BIT] = f_q.src[1];
    end

    assign src_flags = f_q.src;
    assign pm_flag   = f_q.pm;
    assign irq       = f_q.pm && glb_int_en;

    AST_PM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(f_q.pm) |-> $past(pm_int_en)) else $error("pm flag without enable"); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.src[0] && !clr_src[0]) |=> f_q.src[0]) else $error("flag dropped"); // R7
endmodule

// File: rtl/eth_sleep_ctrl.sv
module eth_sleep_ctrl
    import eth_sleep_pkg::*;
#(
    parameter int               CMD_W      = 4,
    parameter logic [CMD_W-1:0] SLEEP_CODE = 4'b1100,
    parameter logic [CMD_W-1:0] LEAVE_CODE = 4'b1101,
    parameter int               EVT_W      = 8,
    parameter int               MP_BIT     = 5,
    parameter int               WF_BIT     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_code,
    input  logic             mp_wake_en,
    input  logic             wf_wake_en,
    input  logic             pm_int_en,
    input  logic             glb_int_en,
    input  logic             mp_detect,
    input  logic             wf_detect,
    input  logic             clr_mp_evt,
    input  logic             clr_wf_evt,
    input  logic             clr_pm_flag,
    output logic             asleep,
    output logic             normal_op,
    output logic             entry_by_cmd,
    output logic [EVT_W-1:0] evt_flags,
    output logic             pm_flag,
    output logic             irq
);
    ctrl_s r_d, r_q;

    logic            go_sleep, go_leave, any_wake, resume_ok;
    logic [NSRC-1:0] accepted, src_flags, enables;

    assign enables = {wf_wake_en, mp_wake_en};

    esc_cmd_decode #(
        .CMD_W     (CMD_W),
        .SLEEP_CODE(SLEEP_CODE),
        .LEAVE_CODE(LEAVE_CODE)
    ) u_dec (
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .go_sleep (go_sleep),
        .go_leave (go_leave)
    );

    esc_wake_qual u_qual (
        .asleep  (r_q.state == PM_SLEEP),
        .by_cmd  (r_q.by_cmd),
        .detect  ({wf_detect, mp_detect}),
        .enable  (enables),
        .accepted(accepted),
        .any_wake(any_wake)
    );

    esc_event_flags #(
        .EVT_W (EVT_W),
        .MP_BIT(MP_BIT),
        .WF_BIT(WF_BIT)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .accepted  (accepted),
        .any_wake  (any_wake),
        .clr_src   ({clr_wf_evt, clr_mp_evt}),
        .clr_pm    (clr_pm_flag),
        .pm_int_en (pm_int_en),
        .glb_int_en(glb_int_en),
        .src_flags (src_flags),
        .evt_flags (evt_flags),
        .pm_flag   (pm_flag),
        .irq       (irq)
    );

    assign resume_ok = !(|enables) && !(|src_flags) && !pm_flag
                       && (!r_q.by_cmd || r_q.exit_seen);

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            PM_NORMAL: begin
                if (go_sleep) begin
                    r_d.state     = PM_SLEEP;
                    r_d.by_cmd    = 1'b1;
                    r_d.exit_seen = 1'b0;
                end else if (|enables) begin
                    r_d.state     = PM_SLEEP;
                    r_d.by_cmd    = 1'b0;
                    r_d.exit_seen = 1'b0;
                end
            end
            PM_SLEEP: begin
                if (go_leave && r_q.by_cmd) r_d.exit_seen = 1'b1;
                if (any_wake || (go_leave && r_q.by_cmd)) r_d.state = PM_WOKEN;
            end
            PM_WOKEN: begin
                if (go_leave) r_d.exit_seen = 1'b1;
                if (resume_ok) begin
                    r_d.state     = PM_NORMAL;
                    r_d.by_cmd    = 1'b0;
                    r_d.exit_seen = 1'b0;
                end
            end
            default: r_d = '{state: PM_NORMAL, by_cmd: 1'b0, exit_seen: 1'b0};
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: PM_NORMAL, by_cmd: 1'b0, exit_seen: 1'b0};
        else        r_q <= r_d;
    end

    assign asleep       = (r_q.state == PM_SLEEP);
    assign normal_op    = (r_q.state == PM_NORMAL);
    assign entry_by_cmd = r_q.by_cmd;

    AST_CMD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_op && cmd_valid && cmd_code == SLEEP_CODE) |=> (asleep && entry_by_cmd)) else $error("cmd entry"); // R1

    AST_EN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (normal_op && !(cmd_valid && cmd_code == SLEEP_CODE) && (mp_wake_en || wf_wake_en))
        |=> (asleep && !entry_by_cmd)) else $error("enable entry"); // R2

    AST_EN_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (asleep && !entry_by_cmd && !(mp_detect && mp_wake_en) && !(wf_detect && wf_wake_en))
        |=> asleep) else $error("enable sleep left early"); // R4

    AST_AWAKE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!asleep && !evt_flags[MP_BIT]) |=> !evt_flags[MP_BIT]) else $error("flag while awake"); // R10

    AST_RESUME_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(normal_op) |-> ($past(!mp_wake_en && !wf_wake_en && !pm_flag && evt_flags == '0)
                              && !entry_by_cmd)) else $error("resume with pending state"); // R8
endmodule

// File: tb/eth_sleep_ctrl_tb.sv
module eth_sleep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 0, mp_wake_en = 0, wf_wake_en = 0, pm_int_en = 0, glb_int_en = 0;
    logic [3:0] cmd_code = '0;
    logic       mp_detect = 0, wf_detect = 0, clr_mp_evt = 0, clr_wf_evt = 0, clr_pm_flag = 0;
    logic       asleep, normal_op, entry_by_cmd, pm_flag, irq;
    logic [7:0] evt_flags;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // bench model: 0 normal, 1 sleep, 2 woken
    int m_st = 0;
    bit m_cmd = 0, m_exit = 0, m_mp = 0, m_wf = 0, m_pm = 0;

    always #5 clk = ~clk;

    eth_sleep_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .mp_wake_en(mp_wake_en), .wf_wake_en(wf_wake_en), .pm_int_en(pm_int_en),
        .glb_int_en(glb_int_en), .mp_detect(mp_detect), .wf_detect(wf_detect),
        .clr_mp_evt(clr_mp_evt), .clr_wf_evt(clr_wf_evt), .clr_pm_flag(clr_pm_flag),
        .asleep(asleep), .normal_op(normal_op), .entry_by_cmd(entry_by_cmd),
        .evt_flags(evt_flags), .pm_flag(pm_flag), .irq(irq)
    );

    function automatic logic [7:0] exp_evt();
        logic [7:0] v = '0;
        v[5] = m_mp;
        v[6] = m_wf;
        return v;
    endfunction

    task automatic model_step();
        bit s_cmd, l_cmd, a_mp, a_wf, wake, ok;
        s_cmd = cmd_valid && cmd_code == 4'b1100;
        l_cmd = cmd_valid && cmd_code == 4'b1101;
        a_mp  = (m_st == 1) && mp_detect && (m_cmd || mp_wake_en);
        a_wf  = (m_st == 1) && wf_detect && (m_cmd || wf_wake_en);
        wake  = a_mp || a_wf;
        ok    = !mp_wake_en && !wf_wake_en && !m_mp && !m_wf && !m_pm && (!m_cmd || m_exit);
        case (m_st)
            0: if (s_cmd) begin m_st = 1; m_cmd = 1; m_exit = 0; end
               else if (mp_wake_en || wf_wake_en) begin m_st = 1; m_cmd = 0; m_exit = 0; end
            1: begin
                if (l_cmd && m_cmd) m_exit = 1;
                if (wake || (l_cmd && m_cmd)) m_st = 2;
            end
            default: begin
                if (l_cmd) m_exit = 1;
                if (ok) begin m_st = 0; m_cmd = 0; m_exit = 0; end
            end
        endcase
        if (a_mp) m_mp = 1; else if (clr_mp_evt) m_mp = 0;
        if (a_wf) m_wf = 1; else if (clr_wf_evt) m_wf = 0;
        if (wake && pm_int_en) m_pm = 1; else if (clr_pm_flag) m_pm = 0;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R3", "asleep", int'(asleep), int'(m_st == 1));
        chk("R5", "evt_flags", int'(evt_flags), int'(exp_evt()));
        chk("R6", "pm_flag", int'(pm_flag), int'(m_pm));
        chk("R6", "irq", int'(irq), int'(m_pm && glb_int_en));
        chk("R8", "normal_op", int'(normal_op), int'(m_st == 0));
        chk("R8", "entry_by_cmd", int'(entry_by_cmd), int'(m_cmd));
    endtask

    // one clock: model follows the edge, outputs compared at the falling edge, pulses dropped
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
        cmd_valid = 0; mp_detect = 0; wf_detect = 0;
        clr_mp_evt = 0; clr_wf_evt = 0; clr_pm_flag = 0;
    endtask

    task automatic send_cmd(input logic [3:0] c);
        cmd_valid = 1; cmd_code = c;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "normal_op", int'(normal_op), 1);
        chk("R11", "asleep", int'(asleep), 0);
        chk("R11", "entry_by_cmd", int'(entry_by_cmd), 0);
        chk("R11", "evt_flags", int'(evt_flags), 0);
        chk("R11", "irq", int'(irq + pm_flag), 0);

        // R9 unknown code ignored
        send_cmd(4'b0011); step();
        chk("R9", "normal_op after other code", int'(normal_op), 1);
        // R10 detection while awake
        mp_detect = 1; wf_detect = 1; step();
        chk("R10", "evt_flags awake", int'(evt_flags), 0);

        // command entry, wake by disabled pattern source
        pm_int_en = 1; glb_int_en = 1;
        send_cmd(4'b1100); step();
        chk("R1", "asleep", int'(asleep), 1);
        chk("R1", "entry_by_cmd", int'(entry_by_cmd), 1);
        send_cmd(4'b1100); step();
        chk("R9", "sleep cmd while asleep", int'(asleep), 1);
        wf_detect = 1; step();
        chk("R3", "woken by pattern", int'(asleep), 0);
        chk("R5", "bit6", int'(evt_flags), 8'h40);
        chk("R6", "irq", int'(irq), 1);
        glb_int_en = 0; #1;
        chk("R6", "irq gated", int'(irq), 0);
        glb_int_en = 1;
        step();
        chk("R7", "flag sticky", int'(evt_flags), 8'h40);
        clr_wf_evt = 1; clr_pm_flag = 1; step();
        chk("R7", "cleared", int'(evt_flags + pm_flag), 0);
        step();
        chk("R8", "needs leave cmd", int'(normal_op), 0);
        send_cmd(4'b1101); step();
        step();
        chk("R8", "resumed", int'(normal_op), 1);

        // enable entry, leave command ignored
        pm_int_en = 0; mp_wake_en = 1; step();
        chk("R2", "asleep", int'(asleep), 1);
        chk("R2", "entry_by_cmd", int'(entry_by_cmd), 0);
        send_cmd(4'b1101); step();
        chk("R4", "leave ignored", int'(asleep), 1);
        wf_detect = 1; step();
        chk("R4", "disabled source ignored", int'(asleep), 1);
        mp_detect = 1; step();
        chk("R4", "woken by enabled", int'(asleep), 0);
        chk("R5", "bit5", int'(evt_flags), 8'h20);
        chk("R6", "no pm flag", int'(pm_flag), 0);
        step();
        chk("R8", "enable still set", int'(normal_op), 0);
        mp_wake_en = 0; clr_mp_evt = 1; step();
        step();
        chk("R8", "resumed enable route", int'(normal_op), 1);

        // constrained random
        begin
            int unused_seed;
            unused_seed = $urandom(32'd20240611);
        end
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 3) mp_wake_en = ~mp_wake_en;
            else if (r < 6) wf_wake_en = ~wf_wake_en;
            if ($urandom_range(0, 9) == 0) pm_int_en = ~pm_int_en;
            if ($urandom_range(0, 9) == 0) glb_int_en = ~glb_int_en;
            if ($urandom_range(0, 5) == 0) begin
                r = $urandom_range(0, 3);
                send_cmd(r == 0 ? 4'b1100 : r == 1 ? 4'b1101 : 4'($urandom_range(0, 15)));
            end
            mp_detect   = ($urandom_range(0, 7) == 0);
            wf_detect   = ($urandom_range(0, 7) == 0);
            clr_mp_evt  = ($urandom_range(0, 5) == 0);
            clr_wf_evt  = ($urandom_range(0, 5) == 0);
            clr_pm_flag = ($urandom_range(0, 5) == 0);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule